// File: doc/BRIEF.md
# Attenuator Gain Decoder with Fast-Attack Step

This block turns a programmed 6-bit gain code, a 2-bit step selector and one external fast-attack pin into a control vector for a step attenuator. Each code step is 0.5 dB of attenuation. Code 0 is the highest gain and code 40 is the deepest setting. A programmed code above 40 is clamped to 40.

While the fast-attack pin is high, the block adds an extra attenuation of 2, 4, 8 or 16 dB, which is 4, 8, 16 or 32 code steps, to the clamped programmed code. The sum is clamped to 40 again. The resulting effective code drives a 40-bit thermometer vector. Both the vector and the effective code come out of registers, so every attenuator bit switches on the same clock edge. No intermediate binary code ever reaches the attenuator.

An enable input forces the whole output to zero. The programmed code and the selector come from a register interface. The fast-attack pin comes from outside the chip.

Top module: `atten_gain_decoder`

## Requirements
- R1: During synchronous active-high reset, and on the first clock after it, `therm_q` is all zeros and `eff_code_q` is 0.
- R2: With `fa_pin` low and `enable` high, `eff_code_q` equals `gain_code` for any code from 0 to 40.
- R3: With `fa_pin` low, a `gain_code` from 41 to 63 gives `eff_code_q` = 40.
- R4: With `fa_pin` high, the clamped programmed code is increased by a step chosen by `step_sel`: 0 adds 4, 1 adds 8, 2 adds 16 and 3 adds 32.
- R5: When the result of R4 exceeds 40, `eff_code_q` is 40. `eff_code_q` never exceeds 40.
- R6: `therm_q` is 40 bits wide. Bit i is 1 exactly when i < `eff_code_q`, so the lowest N bits are set.
- R7: Outputs reflect the inputs sampled at the previous rising clock edge, with one cycle of latency. When `fa_pin` falls, the next clock edge returns the output to the programmed code.
- R8: With `enable` low, the next clock edge gives `therm_q` all zeros and `eff_code_q` 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output enable; low forces zero attenuation |
| gain_code | input | 6 | Programmed attenuation code, 0.5 dB per step |
| step_sel | input | 2 | Fast-attack step selector |
| fa_pin | input | 1 | Fast-attack request |
| therm_q | output | 40 | Registered thermometer attenuator control |
| eff_code_q | output | 6 | Registered effective code |

## Verification
The assertions check three things on every cycle:
- the thermometer vector has as many set bits as the effective code and forms a contiguous run starting at bit 0;
- the effective code never exceeds 40;
- a cycle with `enable` low is followed by all-zero outputs, and a cycle with `fa_pin` low and `enable` high is followed by the clamped programmed code.

Only the bench's scenarios can show the exact step added for each selector value, the clamping at 40 when large steps are added, and the return to the programmed code after the pin falls. The bench covers these with directed cases and with randomly drawn code, selector and pin combinations.

// File: rtl/atten_pkg.sv
package atten_pkg;
  // Width of the programmed and effective codes
  localparam int CODE_W    = 6;
  // Deepest attenuation code (0.5 dB per step)
  localparam int MAX_CODE  = 40;
  // Fast-attack selector width
  localparam int SEL_W     = 2;
  // Smallest fast-attack step in code units (2 dB)
  localparam int BASE_STEP = 4;
endpackage

// File: rtl/atten_code_calc.sv
module atten_code_calc #(
  parameter int CODE_W    = atten_pkg::CODE_W,
  parameter int MAX_CODE  = atten_pkg::MAX_CODE,
  parameter int SEL_W     = atten_pkg::SEL_W,
  parameter int BASE_STEP = atten_pkg::BASE_STEP
) (
  input  logic [CODE_W-1:0] gain_code,
  input  logic [SEL_W-1:0]  step_sel,
  input  logic              fa_pin,
  output logic [CODE_W-1:0] code_out
);
  // Wide enough for max code plus the largest shifted step
  localparam int SUM_W = CODE_W + (1 << SEL_W);

  logic [SUM_W-1:0] base_c, step_c, sum_c;

  always_comb begin
    base_c = (SUM_W'(gain_code) > SUM_W'(MAX_CODE)) ? SUM_W'(MAX_CODE) : SUM_W'(gain_code);
    step_c = fa_pin ? (SUM_W'(BASE_STEP) << step_sel) : '0;
    sum_c  = base_c + step_c;
    if (sum_c > SUM_W'(MAX_CODE)) code_out = CODE_W'(MAX_CODE);
    else                          code_out = sum_c[CODE_W-1:0];
  end

  // Combinational result must stay inside the attenuator range
  always_comb begin
    assert_code_in_range_R5: assert (32'(code_out) <= MAX_CODE);
  end
endmodule

// File: rtl/atten_therm_enc.sv
module atten_therm_enc #(
  parameter int CODE_W   = atten_pkg::CODE_W,
  parameter int MAX_CODE = atten_pkg::MAX_CODE
) (
  input  logic [CODE_W-1:0]   code_in,
  output logic [MAX_CODE-1:0] therm
);
  // One comparator per attenuator segment
  for (genvar i = 0; i < MAX_CODE; i++) begin : g_seg
    assign therm[i] = (32'(code_in) > i);
  end
endmodule

// File: rtl/atten_gain_decoder.sv
module atten_gain_decoder #(
  parameter int CODE_W    = atten_pkg::CODE_W,
  parameter int MAX_CODE  = atten_pkg::MAX_CODE,
  parameter int SEL_W     = atten_pkg::SEL_W,
  parameter int BASE_STEP = atten_pkg::BASE_STEP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [CODE_W-1:0]   gain_code,
  input  logic [SEL_W-1:0]    step_sel,
  input  logic                fa_pin,
  output logic [MAX_CODE-1:0] therm_q,
  output logic [CODE_W-1:0]   eff_code_q
);
  logic [CODE_W-1:0]   eff_c;
  logic [MAX_CODE-1:0] therm_c;

  atten_code_calc #(
    .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .SEL_W(SEL_W), .BASE_STEP(BASE_STEP)
  ) u_calc (
    .gain_code(gain_code),
    .step_sel (step_sel),
    .fa_pin   (fa_pin),
    .code_out (eff_c)
  );

  atten_therm_enc #(
    .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
  ) u_enc (
    .code_in(eff_c),
    .therm  (therm_c)
  );

  // Single register stage: all attenuator bits move on one edge
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      therm_q    <= '0;
      eff_code_q <= '0;
    end else begin
      therm_q    <= therm_c;
      eff_code_q <= eff_c;
    end
  end

  assert_therm_count_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_q) == 32'(eff_code_q));

  assert_therm_contig_R6: assert property (@(posedge clk) disable iff (rst)
    (therm_q & (therm_q + 1'b1)) == '0);

  assert_eff_max_R5: assert property (@(posedge clk) disable iff (rst)
    32'(eff_code_q) <= MAX_CODE);

  assert_disable_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (eff_code_q == '0 && therm_q == '0));

  assert_fa_release_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && !fa_pin) |=>
      (32'(eff_code_q) == ((32'($past(gain_code)) > MAX_CODE) ? MAX_CODE : 32'($past(gain_code)))));
endmodule

// File: tb/test_atten_gain_decoder.sv
module test_atten_gain_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [5:0]  gain_code;
  logic [1:0]  step_sel;
  logic        fa_pin;
  logic [39:0] therm_q;
  logic [5:0]  eff_code_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  atten_gain_decoder i_atten_gain_decoder (
    .clk(clk), .rst(rst), .enable(enable), .gain_code(gain_code),
    .step_sel(step_sel), .fa_pin(fa_pin), .therm_q(therm_q), .eff_code_q(eff_code_q)
  );

  function automatic int exp_code(int g, int s, bit fa, bit en);
    int c;
    if (!en) return 0;
    c = (g > 40) ? 40 : g;
    if (fa) c = c + (4 << s);
    return (c > 40) ? 40 : c;
  endfunction

  function automatic logic [39:0] exp_therm(int n);
    logic [39:0] v = '0;
    for (int i = 0; i < 40; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  // Drive on falling edge, check at next falling edge (one register stage)
  task automatic apply(int g, int s, bit fa, bit en, string req);
    int e;
    gain_code = 6'(g); step_sel = 2'(s); fa_pin = fa; enable = en;
    @(negedge clk);
    e = exp_code(g, s, fa, en);
    total++;
    if (32'(eff_code_q) != e) begin
      bad++;
      $display("FAIL %s code g=%0d s=%0d fa=%0d en=%0d: got %0d exp %0d", req, g, s, fa, en, eff_code_q, e);
    end
    total++;
    if (therm_q !== exp_therm(e)) begin
      bad++;
      $display("FAIL R6/%s therm: got %h exp %h", req, therm_q, exp_therm(e));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    rst = 1'b1; enable = 1'b1; gain_code = 6'd20; step_sel = 2'd3; fa_pin = 1'b1;
    repeat (3) @(negedge clk);
    total++; // R1
    if (eff_code_q != 0 || therm_q != '0) begin
      bad++; $display("FAIL R1 reset: got %0d/%h exp 0/0", eff_code_q, therm_q);
    end
    rst = 1'b0;
    apply(0, 0, 0, 1, "R2");
    apply(24, 0, 0, 1, "R2");
    apply(40, 2, 0, 1, "R2");
    apply(41, 0, 0, 1, "R3");
    apply(63, 3, 0, 1, "R3");
    apply(10, 0, 1, 1, "R4");
    apply(10, 1, 1, 1, "R4");
    apply(10, 2, 1, 1, "R4");
    apply(0, 3, 1, 1, "R4");
    apply(30, 3, 1, 1, "R5");
    apply(37, 0, 1, 1, "R5");
    apply(50, 1, 1, 1, "R5");
    apply(12, 2, 1, 1, "R7");
    apply(12, 2, 0, 1, "R7");
    apply(33, 3, 1, 0, "R8");
    apply(5, 0, 0, 0, "R8");
    apply(7, 0, 0, 1, "R7");
    for (int k = 0; k < 400; k++) begin
      int g = int'($urandom_range(63, 0));
      int s = int'($urandom_range(3, 0));
      bit f = 1'($urandom_range(1, 0));
      bit en = ($urandom_range(7, 0) != 0);
      apply(g, s, f, en, "R4");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule